// File: doc/BRIEF.md
# Windowed Local-Maximum Peak Detector

This block watches a stream of unsigned amplitude samples, one per clock edge, each paired with a minimum-level value presented on the same edge. It marks a sample as a peak when three conditions all hold. The sample reaches its own minimum level. It is strictly larger than the two samples on each side of it. It lies far enough, in sample count, from the previous accepted peak. Because the two later neighbours must arrive first, the decision about a sample is made two edges after it is taken. The result appears as a single-cycle registered pulse.

The block sits after a filtering stage in a cardiac or similar event-detection chain. It keeps a short sample history with the matching delayed levels and a fill count, and it uses a saturating distance counter for the refractory window. A synchronous active-high reset clears all of this state, and the block then starts again from an empty history.

Top module: `peak_win_det`

## Requirements
- R1: The sample taken on edge n (counting from 0 at the first edge with reset low) is judged once the samples of edges n+1 and n+2 are known. When that sample is accepted, `peak_o` is high during the cycle that follows edge n+2.
- R2: A sample is accepted only if its value is greater than or equal to the level presented on its own edge. Equality is enough, and a value one below the level is rejected.
- R3: A sample is accepted only if it is strictly greater than each of the samples taken on edges n-2, n-1, n+1 and n+2. A tie with any one of them rejects it, so a flat top never yields a pulse.
- R4: Each acceptance produces a pulse exactly one cycle long, and `peak_o` is low in every cycle with no acceptance.
- R5: No pulse follows any of edges 0 to 3 after reset release, so the earliest possible pulse is for the sample of edge 2, following edge 4.
- R6: After an accepted sample with index p, a sample with index n and n - p between 1 and 49 is rejected even if it passes R2 and R3. With n - p equal to 50 or more it may be accepted.
- R7: The refractory distance counts sample indices of the judged samples, not pulse cycles. Before the first acceptance after reset, no refractory limit applies.
- R8: While `rst` is high at a clock edge, the history, fill count and refractory state are cleared and `peak_o` is low after that edge. A pulse still pending when reset arrives is lost.
- R9: The level used for a sample is the one presented on that sample's own edge. Levels presented on the neighbours' edges have no effect on its decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one sample per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| smp_i | input | 12 | Unsigned amplitude sample |
| thr_i | input | 12 | Unsigned minimum level for the sample on the same edge |
| peak_o | output | 1 | One-cycle pulse for the sample taken two edges earlier |

## Verification
The bench aims at the edges of each acceptance rule. It tries a level exactly equal to the sample and one above it; a design using a strict compare would lose the first, and one that ignores the level would pass the second. It tries flat tops and ties at distance two, which a non-strict compare would accept. It places candidates at distances 49 and 50 from an accepted peak, which shows an off-by-one in the refractory counter. It also tries a peak on the earliest legal sample after reset, a reset that lands while a pulse is pending, and a peak shortly after such a reset, which would be lost if refractory state outlived the reset. Levels that differ between a sample and its neighbours show whether the level is delayed by the wrong number of stages.

// File: rtl/pkd_pkg.sv
package pkd_pkg;
  // Number of bits to hold values 0..v
  function automatic int unsigned bits_for(input int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction
endpackage

// File: rtl/pkd_window.sv
module pkd_window
  import pkd_pkg::*;
#(
  parameter int unsigned DW   = 12,
  parameter int unsigned HALF = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [DW-1:0]               smp_i,
  input  logic [DW-1:0]               thr_i,
  output logic [2*HALF:0][DW-1:0]     win_o,
  output logic [DW-1:0]               cen_thr_o,
  output logic                        full_o
);
  localparam int unsigned HIST   = 2 * HALF;
  localparam int unsigned FILL_W = bits_for(HIST);
  localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(HIST);

  logic [HIST-1:0][DW-1:0] hist_q, hist_d;
  logic [HALF-1:0][DW-1:0] thr_q, thr_d;
  logic [FILL_W-1:0]       fill_q, fill_d;
  logic                    adv;

  assign adv = 1'b1;

  always_comb begin
    hist_d = hist_q;
    thr_d  = thr_q;
    fill_d = fill_q;
    if (adv) begin
      hist_d[0] = smp_i;
      for (int i = 1; i < HIST; i++) hist_d[i] = hist_q[i-1];
      thr_d[0] = thr_i;
      for (int i = 1; i < HALF; i++) thr_d[i] = thr_q[i-1];
      if (fill_q != FILL_MAX) fill_d = fill_q + FILL_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
      thr_q  <= '0;
      fill_q <= '0;
    end else begin
      hist_q <= hist_d;
      thr_q  <= thr_d;
      fill_q <= fill_d;
    end
  end

  // Newest sample at index 0, oldest at index HIST
  always_comb begin
    win_o[0] = smp_i;
    for (int i = 1; i <= HIST; i++) win_o[i] = hist_q[i-1];
  end

  assign cen_thr_o = thr_q[HALF-1];
  assign full_o    = (fill_q == FILL_MAX);

  // R5: once the window is full it stays full until reset
  assert_full_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    full_o |=> full_o);

  // R8: the fill count restarts from zero after reset
  assert_fill_clear_R8: assert property (@(posedge clk)
    rst |=> (fill_q == '0));
endmodule

// File: rtl/pkd_lmax.sv
module pkd_lmax #(
  parameter int unsigned DW   = 12,
  parameter int unsigned HALF = 2
) (
  input  logic [2*HALF:0][DW-1:0] win_i,
  input  logic [DW-1:0]           cen_thr_i,
  output logic                    cand_o
);
  localparam int unsigned WIN = 2 * HALF + 1;

  logic [WIN-1:0] above;
  logic           level_ok;

  for (genvar i = 0; i < WIN; i++) begin : g_cmp
    if (i == HALF) begin : g_self
      assign above[i] = 1'b1;
    end else begin : g_nbr
      assign above[i] = (win_i[HALF] > win_i[i]);
    end
  end

  assign level_ok = (win_i[HALF] >= cen_thr_i);
  assign cand_o   = level_ok & (&above);

  // R3: a candidate never ties with its nearest neighbours
  always_comb begin
    if (cand_o) begin
      assert_no_tie_R3: assert ((win_i[HALF] != win_i[HALF-1]) && (win_i[HALF] != win_i[HALF+1]));
    end
  end
endmodule

// File: rtl/pkd_refr.sv
module pkd_refr
  import pkd_pkg::*;
#(
  parameter int unsigned GAP = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic full_i,
  input  logic cand_i,
  output logic accept_o
);
  localparam int unsigned DIST_W = bits_for(GAP);
  localparam logic [DIST_W-1:0] GAP_V = DIST_W'(GAP);

  logic              seen_q, seen_d;
  logic [DIST_W-1:0] dist_q, dist_d;
  logic              clear_ok;

  assign clear_ok = !seen_q || (dist_q >= GAP_V);
  assign accept_o = full_i & cand_i & clear_ok;

  always_comb begin
    seen_d = seen_q;
    dist_d = dist_q;
    if (full_i) begin
      if (accept_o) begin
        seen_d = 1'b1;
        dist_d = DIST_W'(1);
      end else if (dist_q < GAP_V) begin
        dist_d = dist_q + DIST_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= 1'b0;
      dist_q <= '0;
    end else begin
      seen_q <= seen_d;
      dist_q <= dist_d;
    end
  end

  // R6: distance counter saturates and never wraps
  assert_dist_sat_R6: assert property (@(posedge clk) disable iff (rst)
    dist_q <= GAP_V);

  // R7: after an acceptance the next judged sample is at distance one
  assert_dist_restart_R7: assert property (@(posedge clk) disable iff (rst)
    accept_o |=> (dist_q == DIST_W'(1)));
endmodule

// File: rtl/peak_win_det.sv
module peak_win_det
  import pkd_pkg::*;
#(
  parameter int unsigned DW   = 12,
  parameter int unsigned HALF = 2,
  parameter int unsigned GAP  = 50
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] smp_i,
  input  logic [DW-1:0] thr_i,
  output logic          peak_o
);
  localparam int unsigned WIN   = 2 * HALF + 1;
  localparam int unsigned CHK_W = bits_for(GAP + WIN);

  logic [WIN-1:0][DW-1:0] win;
  logic [DW-1:0]          cen_thr;
  logic                   full;
  logic                   cand;
  logic                   accept;
  logic                   peak_q, peak_d;

  pkd_window #(.DW(DW), .HALF(HALF)) u_win (
    .clk      (clk),
    .rst      (rst),
    .smp_i    (smp_i),
    .thr_i    (thr_i),
    .win_o    (win),
    .cen_thr_o(cen_thr),
    .full_o   (full)
  );

  pkd_lmax #(.DW(DW), .HALF(HALF)) u_lmax (
    .win_i    (win),
    .cen_thr_i(cen_thr),
    .cand_o   (cand)
  );

  pkd_refr #(.GAP(GAP)) u_refr (
    .clk     (clk),
    .rst     (rst),
    .full_i  (full),
    .cand_i  (cand),
    .accept_o(accept)
  );

  assign peak_d = accept;

  always_ff @(posedge clk) begin
    if (rst) peak_q <= 1'b0;
    else     peak_q <= peak_d;
  end

  assign peak_o = peak_q;

  // Checker state: samples since reset, cycles since last pulse
  logic [CHK_W-1:0] chk_cnt, chk_gap;
  logic             chk_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_cnt  <= '0;
      chk_gap  <= '0;
      chk_seen <= 1'b0;
    end else begin
      if (chk_cnt < CHK_W'(WIN)) chk_cnt <= chk_cnt + CHK_W'(1);
      if (peak_o) begin
        chk_seen <= 1'b1;
        chk_gap  <= CHK_W'(1);
      end else if (chk_gap < CHK_W'(GAP)) begin
        chk_gap <= chk_gap + CHK_W'(1);
      end
    end
  end

  // R5: no pulse before a full window has been taken
  assert_no_early_R5: assert property (@(posedge clk) disable iff (rst)
    peak_o |-> (chk_cnt >= CHK_W'(WIN)));

  // R4: pulses are a single cycle wide
  assert_one_cycle_R4: assert property (@(posedge clk) disable iff (rst)
    peak_o |=> !peak_o);

  // R6: pulses are at least GAP cycles apart
  assert_refr_gap_R6: assert property (@(posedge clk) disable iff (rst)
    (peak_o && chk_seen) |-> (chk_gap >= CHK_W'(GAP)));

  // R8: output low after a reset edge
  assert_rst_quiet_R8: assert property (@(posedge clk)
    rst |=> !peak_o);

  // R2: the judged sample reached its own level
  assert_level_R2: assert property (@(posedge clk) disable iff (rst)
    peak_o |-> $past(win[HALF] >= cen_thr));
endmodule

// File: tb/test_peak_win_det.sv
`timescale 1ns/1ps
module test_peak_win_det;
  logic        clk = 1'b0;
  logic        rst;
  logic [11:0] smp, thr;
  logic        peak;

  always #2.5 clk = ~clk;

  peak_win_det i_peak_win_det (
    .clk   (clk),
    .rst   (rst),
    .smp_i (smp),
    .thr_i (thr),
    .peak_o(peak)
  );

  int    total = 0;
  int    bad   = 0;
  int    xs [4096];
  int    ts [4096];
  int    k      = 0;
  int    last_p = -1;
  bit    exp_q  = 1'b0;
  bit    have_q = 1'b0;
  string tag_q  = "";
  bit    done   = 1'b0;

  task automatic chk(input bit act, input bit exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b (time %0t)", tag, act, exp, $time);
    end
  endtask

  // Expected decision after edge kk, computed from the requirements
  task automatic model(input int kk, output bit acc);
    int  n;
    bit  c;
    acc = 1'b0;
    if (kk < 4) return;
    n = kk - 2;
    c = (xs[n] >= ts[n]) && (xs[n] > xs[n-2]) && (xs[n] > xs[n-1]) &&
        (xs[n] > xs[n+1]) && (xs[n] > xs[n+2]);
    if (!c) return;
    if (last_p >= 0 && (n - last_p) < 50) return;
    last_p = n;
    acc = 1'b1;
  endtask

  task automatic push(input int x, input int t, input string tag);
    bit e;
    @(negedge clk);
    if (have_q) chk(peak, exp_q, tag_q);
    rst = 1'b0;
    smp = 12'(x);
    thr = 12'(t);
    xs[k] = x;
    ts[k] = t;
    model(k, e);
    exp_q  = e;
    tag_q  = tag;
    have_q = 1'b1;
    k++;
  endtask

  task automatic quiet(input int n, input string tag);
    for (int i = 0; i < n; i++) push(0, 0, tag);
  endtask

  task automatic do_reset(input int cyc);
    @(negedge clk);
    if (have_q) chk(peak, exp_q, tag_q);
    have_q = 1'b0;
    rst = 1'b1;
    smp = 12'hFFF;
    thr = 12'h000;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      chk(peak, 1'b0, "R8 output low during reset");
    end
    k = 0;
    last_p = -1;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed_val;
    seed_val = $urandom(32'h00C0FFEE);
    rst = 1'b1;
    smp = '0;
    thr = '0;
    do_reset(3);

    // R5: a tall sample at index 1 cannot be judged; nothing in edges 0..4
    push(5, 0, "R5 early window");
    push(200, 0, "R5 early window");
    push(10, 0, "R5 early window");
    push(5, 0, "R5 early window");
    push(3, 0, "R5 early window");
    quiet(6, "R5 early window");
    do_reset(2);

    // R1 / R5: earliest legal peak (index 2) pulses after edge 4
    push(10, 0, "R1 earliest peak");
    push(20, 0, "R1 earliest peak");
    push(100, 50, "R1 earliest peak");
    push(30, 0, "R1 earliest peak");
    push(5, 0, "R1 earliest peak");
    quiet(60, "R4 low after pulse");

    // R2: level equal accepts, level one above rejects
    push(100, 100, "R2 level equal");
    quiet(60, "R2 level equal");
    push(100, 101, "R2 level above");
    quiet(60, "R2 level above");

    // R3: flat top and tie at distance two
    push(100, 0, "R3 flat top");
    push(100, 0, "R3 flat top");
    quiet(60, "R3 flat top");
    push(100, 0, "R3 tie distance two");
    push(50, 0, "R3 tie distance two");
    push(100, 0, "R3 tie distance two");
    quiet(60, "R3 tie distance two");
    push(90, 0, "R3 rising ramp");
    push(100, 0, "R3 rising ramp");
    push(99, 0, "R3 rising ramp");
    push(98, 0, "R3 rising ramp");
    quiet(60, "R3 rising ramp");

    // R6: distance 49 rejected, distance 50 accepted
    push(300, 0, "R6 first peak");
    quiet(48, "R6 gap 49");
    push(300, 0, "R6 gap 49 rejected");
    quiet(60, "R6 gap 49");
    push(300, 0, "R6 first peak");
    quiet(49, "R6 gap 50");
    push(300, 0, "R6 gap 50 accepted");
    quiet(60, "R6 gap 50");

    // R7: distance measured from accepted samples; a rejected one does not restart it
    push(400, 0, "R7 anchor");
    quiet(20, "R7 chain");
    push(400, 0, "R7 rejected mid");
    quiet(28, "R7 chain");
    push(400, 0, "R7 accepted at 50 from anchor");
    quiet(60, "R7 chain");

    // R9: neighbours' levels do not matter, only the own level does
    push(0, 4095, "R9 own level");
    push(0, 4095, "R9 own level");
    push(100, 100, "R9 own level");
    push(0, 4095, "R9 own level");
    push(0, 4095, "R9 own level");
    quiet(60, "R9 own level");
    push(0, 0, "R9 high own level");
    push(0, 0, "R9 high own level");
    push(100, 4095, "R9 high own level");
    push(0, 0, "R9 high own level");
    push(0, 0, "R9 high own level");
    quiet(60, "R9 high own level");

    // R1 R4: random stream
    for (int i = 0; i < 2000; i++) begin
      int x;
      int t;
      if (($urandom % 8) == 0) x = int'($urandom % 4096);
      else                     x = int'($urandom % 256);
      t = int'($urandom % 2048);
      push(x, t, "R1 R4 random stream");
    end
    quiet(4, "R4 random tail");

    // R8: reset while a pulse is pending; then R7 no carry-over of refractory state
    push(0, 0, "R8 pending");
    push(0, 0, "R8 pending");
    push(500, 0, "R8 pending");
    push(0, 0, "R8 pending");
    do_reset(2);
    push(0, 0, "R7 fresh after reset");
    push(0, 0, "R7 fresh after reset");
    push(700, 0, "R7 fresh after reset");
    push(0, 0, "R7 fresh after reset");
    push(0, 0, "R7 fresh after reset");
    quiet(8, "R8 history cleared");

    @(negedge clk);
    if (have_q) chk(peak, exp_q, tag_q);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule